// File: doc/BRIEF.md
# Lookup-Table Word Processing Element

This block is one processing element of a word-oriented reconfigurable fabric. It is a row of identical one-bit slices. Each slice evaluates two programmable three-input functions, both addressed by the same three bits: one A bit, one B bit and a third bit that ripples in from the next lower slice. The first function gives the slice's result bit. The second gives the bit passed up to the next slice. Because both functions come from configuration tables and not from an opcode decoder, the same element can be set up as an adder, a subtractor, a bitwise gate or any other three-input function per bit.

A configuration word is captured when its write enable is high at a clock edge. Besides the two tables, the word holds a two-bit selector for the lowest slice's third input and two single-bit routing switches. One switch chooses where the A operand comes from. The other chooses where the B operand comes from. The result word and the top slice's ripple output are registered. Feeding the registered result back as operand A turns the element into an accumulator.

Top module: `lut_word_pe`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every configuration bit, the result register and the cout register, so result and cout read 0 after that edge and stay 0 until a configuration is loaded.
- R2: With an all-zero result table the result is 0 for every operand and carry pattern.
- R3: Result bit i equals bit {c_i, b_i, a_i} (index = 4*c_i + 2*b_i + a_i) of the result table, where a_i and b_i are the routed operand bits and c_i is the slice's third input.
- R4: The third input of slice i+1 equals bit {c_i, b_i, a_i} of the ripple table, and cout is the ripple output of the top slice.
- R5: The lowest slice's third input is selected by a two-bit field: 00 gives constant 0, 01 gives constant 1, 10 gives the cin port, and 11 gives constant 0.
- R6: The configuration word is laid out as follows: bits [7:0] are the result table, bits [15:8] the ripple table, bits [17:16] the lowest-slice selector, bit 18 the A-source switch and bit 19 the B-source switch.
- R7: The configuration changes only at a clock edge where cfg_we is high. When cfg_we is low, cfg_data is ignored.
- R8: result and cout appear at the clock edge after the operands are presented and do not change between edges. At an edge where a configuration is also written, they are computed with the configuration held before that edge.
- R9: A-source switch 0 routes op_a to the A inputs. Switch 1 routes the registered result word instead, and op_a is then ignored.
- R10: B-source switch 0 routes op_b to the B inputs. Switch 1 routes op_a instead, and op_b is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_data | input | 20 | Configuration word (layout in R6) |
| op_a | input | 8 | Operand word A |
| op_b | input | 8 | Operand word B |
| cin | input | 1 | External carry into the lowest slice |
| result | output | 8 | Registered result word |
| cout | output | 1 | Registered ripple output of the top slice |

## Verification
A configuration write and a computation can happen at the same clock edge. The bench loads a bitwise AND setup, then holds cfg_we high with an adder setup while presenting 0x0F and 0x01 in that same cycle. The result after that edge must be the AND value 0x01, and the next edge with unchanged operands must give the sum 0x10. The accumulator feedback path also combines a configuration write with a running computation. The bench writes the feedback setup while a sum is still being formed, then checks that each later edge adds op_b to the previous result.

// File: rtl/lut_pe_pkg.sv
package lut_pe_pkg;

  localparam int TAB_N = 8;

  typedef enum logic [1:0] {
    CSEL_ZERO = 2'b00,
    CSEL_ONE  = 2'b01,
    CSEL_EXT  = 2'b10,
    CSEL_RSVD = 2'b11
  } csel_e;

  typedef struct packed {
    logic              b_from_a;
    logic              a_from_res;
    csel_e             csel;
    logic [TAB_N-1:0]  ripple_tab;
    logic [TAB_N-1:0]  sum_tab;
  } pe_cfg_t;

  localparam int CFG_W = $bits(pe_cfg_t);

  function automatic logic tab3(input logic [TAB_N-1:0] tab,
                                input logic a, input logic b, input logic c);
    return tab[{c, b, a}];
  endfunction

  function automatic logic pick_c0(input csel_e sel, input logic ext);
    case (sel)
      CSEL_ONE: return 1'b1;
      CSEL_EXT: return ext;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lut_pe_cfg_store.sv
module lut_pe_cfg_store
  import lut_pe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] din,
  output pe_cfg_t          cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= pe_cfg_t'(din);
    end
  end

endmodule

// File: rtl/lut_pe_route.sv
module lut_pe_route #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] res_fb,
  input  logic         a_from_res,
  input  logic         b_from_a,
  output logic [W-1:0] a_eff,
  output logic [W-1:0] b_eff
);

  always_comb begin
    a_eff = a_from_res ? res_fb : op_a;
    b_eff = b_from_a   ? op_a   : op_b;
  end

endmodule

// File: rtl/lut_pe_slice.sv
module lut_pe_slice
  import lut_pe_pkg::*;
(
  input  logic [TAB_N-1:0] sum_tab,
  input  logic [TAB_N-1:0] ripple_tab,
  input  logic             a,
  input  logic             b,
  input  logic             c,
  output logic             s,
  output logic             co
);

  always_comb begin
    s  = tab3(sum_tab, a, b, c);
    co = tab3(ripple_tab, a, b, c);
  end

endmodule

// File: rtl/lut_pe_chain.sv
module lut_pe_chain
  import lut_pe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [TAB_N-1:0] sum_tab,
  input  logic [TAB_N-1:0] ripple_tab,
  input  logic [W-1:0]     a_vec,
  input  logic [W-1:0]     b_vec,
  input  logic             c0,
  output logic [W-1:0]     s_vec,
  output logic             c_top
);

  logic [W:0] c_link;

  assign c_link[0] = c0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    lut_pe_slice u_slice (
      .sum_tab    (sum_tab),
      .ripple_tab (ripple_tab),
      .a          (a_vec[i]),
      .b          (b_vec[i]),
      .c          (c_link[i]),
      .s          (s_vec[i]),
      .co         (c_link[i+1])
    );
  end

  assign c_top = c_link[W];

endmodule

// File: rtl/lut_word_pe.sv
module lut_word_pe
  import lut_pe_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] result,
  output logic             cout
);

  pe_cfg_t          cfg_q;
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;
  logic             slice0_c;
  logic [WIDTH-1:0] comb_res;
  logic             comb_cout;
  logic [WIDTH-1:0] res_q;
  logic             cout_q;

  lut_pe_cfg_store u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .din   (cfg_data),
    .cfg_q (cfg_q)
  );

  lut_pe_route #(.W(WIDTH)) u_route (
    .op_a       (op_a),
    .op_b       (op_b),
    .res_fb     (res_q),
    .a_from_res (cfg_q.a_from_res),
    .b_from_a   (cfg_q.b_from_a),
    .a_eff      (a_eff),
    .b_eff      (b_eff)
  );

  assign slice0_c = pick_c0(cfg_q.csel, cin);

  lut_pe_chain #(.W(WIDTH)) u_chain (
    .sum_tab    (cfg_q.sum_tab),
    .ripple_tab (cfg_q.ripple_tab),
    .a_vec      (a_eff),
    .b_vec      (b_eff),
    .c0         (slice0_c),
    .s_vec      (comb_res),
    .c_top      (comb_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      res_q  <= comb_res;
      cout_q <= comb_cout;
    end
  end

  assign result = res_q;
  assign cout   = cout_q;

endmodule

// File: rtl/lut_word_pe_chk.sv
module lut_word_pe_chk
  import lut_pe_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  pe_cfg_t          cfg_q,
  input  logic             cin,
  input  logic [WIDTH-1:0] result,
  input  logic             cout
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !cout && cfg_q == '0));

  p_zero_table_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sum_tab == '0) |=> (result == '0));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_q));

  p_cfg_load_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_q == pe_cfg_t'($past(cfg_data))));

  // R5: result table 0xF0 copies the third input into result bit 0
  p_c0_one_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sum_tab == 8'hF0 && cfg_q.csel == CSEL_ONE) |=> result[0]);

  p_c0_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sum_tab == 8'hF0 && (cfg_q.csel == CSEL_ZERO || cfg_q.csel == CSEL_RSVD))
      |=> !result[0]);

  p_c0_ext_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sum_tab == 8'hF0 && cfg_q.csel == CSEL_EXT) |=> (result[0] == $past(cin)));

endmodule

bind lut_word_pe lut_word_pe_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_data (cfg_data),
  .cfg_q    (cfg_q),
  .cin      (cin),
  .result   (result),
  .cout     (cout)
);

// File: tb/test_lut_word_pe.sv
`timescale 1ns/1ps
module test_lut_word_pe;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [19:0] cfg_data = '0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic        cin = 1'b0;
  logic [7:0]  result;
  logic        cout;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lut_word_pe i_lut_word_pe (
    .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_data (cfg_data),
    .op_a (op_a), .op_b (op_b), .cin (cin), .result (result), .cout (cout)
  );

  // {cfg[19:0], a, b, cin, {cout, result}}
  localparam int NV = 13;
  localparam logic [45:0] VEC [NV] = '{
    {20'h2E896, 8'h12, 8'h34, 1'b0, 9'h046},
    {20'h2E896, 8'hFF, 8'h01, 1'b0, 9'h100},
    {20'h2E896, 8'h80, 8'h80, 1'b1, 9'h101},
    {20'h1E896, 8'h0F, 8'h00, 1'b0, 9'h010},
    {20'h3E896, 8'h0F, 8'h00, 1'b1, 9'h00F},
    {20'h0E896, 8'hFF, 8'h00, 1'b1, 9'h0FF},
    {20'h00088, 8'hF0, 8'h3C, 1'b0, 9'h030},
    {20'h00066, 8'hAA, 8'h0F, 1'b0, 9'h0A5},
    {20'h1F0F0, 8'h00, 8'h00, 1'b0, 9'h1FF},
    {20'h1B269, 8'h50, 8'h20, 1'b0, 9'h130},
    {20'h1B269, 8'h20, 8'h50, 1'b0, 9'h0D0},
    {20'hAE896, 8'h41, 8'hFF, 1'b0, 9'h082},
    {20'h00000, 8'hFF, 8'hFF, 1'b1, 9'h000}
  };
  localparam string TAG [NV] = '{
    "R3 R4 R6 add", "R4 add carry out", "R4 R5 add ext cin",
    "R5 const one", "R5 code 11", "R5 const zero ignores cin",
    "R3 and", "R3 xor", "R4 R5 ripple only",
    "R3 R4 subtract", "R4 subtract borrow", "R10 b from a", "R2 zero table"
  };

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %03h expected %03h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(); tick();
    chk("R1 reset outputs", {cout, result}, 9'h000);
    rst = 1'b0;
    op_a = 8'hFF; op_b = 8'hFF; cin = 1'b1;
    tick();
    chk("R2 unconfigured", {cout, result}, 9'h000);
    // load adder, then reset mid-run
    cfg_we = 1'b1; cfg_data = 20'h2E896; op_a = 8'h01; op_b = 8'h01; cin = 1'b0;
    tick();
    cfg_we = 1'b0;
    tick();
    chk("R3 adder before reset", {cout, result}, 9'h002);
    rst = 1'b1;
    tick();
    chk("R1 reset clears outputs", {cout, result}, 9'h000);
    rst = 1'b0;
    tick();
    chk("R1 reset clears configuration", {cout, result}, 9'h000);

    // vector table
    for (int k = 0; k < NV; k++) begin
      cfg_we = 1'b1; cfg_data = VEC[k][45:26];
      tick();
      cfg_we = 1'b0; cfg_data = ~VEC[k][45:26];   // R7: ignored while cfg_we low
      op_a = VEC[k][25:18]; op_b = VEC[k][17:10]; cin = VEC[k][9];
      tick();
      chk(TAG[k], {cout, result}, VEC[k][8:0]);
    end

    // R8: write and compute in the same cycle
    cfg_we = 1'b1; cfg_data = 20'h00088;
    tick();
    cfg_data = 20'h2E896; op_a = 8'h0F; op_b = 8'h01; cin = 1'b0;
    tick();
    chk("R8 same-cycle write uses old config", {cout, result}, 9'h001);
    cfg_we = 1'b0; cfg_data = 20'h00000;
    op_a = 8'hF0; op_b = 8'hF0;
    #1;
    chk("R8 output held between edges", {cout, result}, 9'h001);
    op_a = 8'h0F; op_b = 8'h01;
    tick();
    chk("R7 R8 new config after edge", {cout, result}, 9'h010);

    // R9: accumulator feedback
    cfg_we = 1'b1; cfg_data = 20'h4E896;
    tick();
    chk("R8 feedback write cycle", {cout, result}, 9'h010);
    cfg_we = 1'b0; op_a = 8'hEE; op_b = 8'h05;
    tick();
    chk("R9 accumulate step 1", {cout, result}, 9'h015);
    tick();
    chk("R9 accumulate step 2", {cout, result}, 9'h01A);
    tick();
    chk("R9 accumulate step 3", {cout, result}, 9'h01F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule